// File: doc/BRIEF.md
# CPU Hotplug Control Register Window

This block is a small byte-addressed register window that keeps a status record for each hot-pluggable processor slot. Each record holds a present flag, an insert-pending flag, a remove-pending flag, a firmware-remove request flag, a 64-bit architectural ID and two OST words (event and status). Software picks one slot by writing a 32-bit selector. It then reads or acts on that slot's flags, writes a command byte, and moves data through two 32-bit data ports. The value those ports return depends on the command that is active.

Platform logic reports slot changes on per-slot strobe inputs: a plug (marked either as a runtime hot-add or as a boot-time population), an unplug request, and a finished unplug. Runtime changes raise a one-cycle event interrupt. A firmware command scans from the selected slot for the next slot with pending work, and the selector moves to that slot. A successful eject raises a per-slot eject request. A write of an OST status word raises a report strobe, and the slot, event word and status word are presented with it. Slot IDs come from a parameterised base-plus-stride table.

Top module: `cpuhp_regwin`

## Requirements
- R1: After reset, the selector, the command register, all slot flags and all OST words are zero. With slot 0 selected, a flags read returns 0 and an offset-8 read returns 0.
- R2: When the selector is not below NSLOT, every read returns zero. Writes to words other than offset 0 are dropped, so the command, the flags and the OST words keep their values.
- R3: A flags read (offset 4, byte lane 0) returns bit0 = present, bit1 = insert pending, bit2 = remove pending and bit4 = firmware-remove requested. All other bits read as zero.
- R4: A flags write performs only the first matching action, in this priority order: bit1 clears insert pending; else bit2 clears remove pending; else bit3 ejects; else bit4 sets firmware-remove.
- R5: An eject or a firmware-remove set is refused for slot 0 and for an absent slot. An accepted eject pulses eject_req for that slot in the write cycle, and clears present and firmware-remove.
- R6: A byte written to offset 5 selects the command: 0 = scan for the next pending slot, 1 = OST event write, 2 = OST status write, 3 = ID read. A value of 4 or more is ignored and the previous command stays in force.
- R7: With command 3, offset 8 reads the low 32 bits of the selected slot's ID and offset 0 reads the high 32 bits. With command 0, offset 8 reads the selector and offset 0 reads zero. With any other command, both ports read zero.
- R8: A write to offset 8 stores the OST event word under command 1, and the OST status word under command 2. A status write asserts ost_stb in the next cycle for one cycle, together with the slot number, the stored event word and the new status word.
- R9: plug_stb sets present. It sets insert pending only when plug_hot is 1. unplug_req sets remove pending. unplug_done clears present. evt_irq is high in the cycle after any hot plug or unplug request, and low otherwise.
- R10: Writing command 0 moves the selector to the first slot that has insert, remove or firmware-remove pending. The search starts at the current selector, includes it, and wraps past NSLOT-1 to 0. The selector is unchanged if no slot has anything pending.
- R11: Byte enables apply per lane. A selector write updates only the enabled bytes. Flags actions use lane 0 of offset 4 and command writes use lane 1, so a write that enables only one of the two lanes leaves the other unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the word |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, combinational during a read |
| plug_stb | input | NSLOT | Per-slot plug event |
| plug_hot | input | NSLOT | Plug is a runtime hot-add |
| unplug_req | input | NSLOT | Per-slot unplug request |
| unplug_done | input | NSLOT | Per-slot unplug completed |
| evt_irq | output | 1 | Event interrupt pulse |
| eject_req | output | NSLOT | Accepted eject, one pulse per slot |
| ost_stb | output | 1 | OST status report strobe |
| ost_slot | output | 32 | Slot of the report |
| ost_event | output | 32 | Stored event word of that slot |
| ost_status | output | 32 | Status word just written |

## Verification
The bench targets the flag-write priority. A design that tested the bits independently would clear remove pending and eject in the same write, or set firmware-remove on a slot it had just ejected. It drives scans that must wrap past the last slot and scans that must stay put when nothing is pending. A search that started after the selector, or that failed to wrap, would land on the wrong slot. It also parks the selector out of range and writes a command there: a design that still accepted the write would change what later ID reads return. Finally, it checks that slot 0 and absent slots refuse ejects, that out-of-range command codes are dropped, and that per-lane writes do not leak between the flags and command bytes.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

  typedef enum logic [7:0] {
    CMD_SCAN   = 8'd0,
    CMD_OST_EV = 8'd1,
    CMD_OST_ST = 8'd2,
    CMD_ID     = 8'd3
  } cmd_e;

  localparam logic [7:0] CMD_LIMIT = 8'd4;

  // Status byte layout seen on reads of offset 4.
  function automatic logic [7:0] pack_flags(input logic pres, input logic ins,
                                            input logic rmv, input logic fwr);
    return {3'b000, fwr, 1'b0, rmv, ins, pres};
  endfunction

  // Lane-wise merge of a write into a 32-bit register.
  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  // Architectural ID of slot idx.
  function automatic logic [63:0] slot_id(input logic [63:0] base,
                                          input logic [63:0] stride,
                                          input int unsigned idx);
    return base + stride * 64'(idx);
  endfunction

endpackage

// File: rtl/cpuhp_slot_bank.sv
module cpuhp_slot_bank #(
  parameter int NSLOT = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] plug_stb,
  input  logic [NSLOT-1:0] plug_hot,
  input  logic [NSLOT-1:0] unplug_req,
  input  logic [NSLOT-1:0] unplug_done,
  input  logic [NSLOT-1:0] clr_ins,
  input  logic [NSLOT-1:0] clr_rmv,
  input  logic [NSLOT-1:0] do_eject,
  input  logic [NSLOT-1:0] set_fwr,
  output logic [NSLOT-1:0] present,
  output logic [NSLOT-1:0] ins_pend,
  output logic [NSLOT-1:0] rmv_pend,
  output logic [NSLOT-1:0] fwr_pend
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic p_q, i_q, r_q, f_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        i_q <= 1'b0;
        r_q <= 1'b0;
        f_q <= 1'b0;
      end else begin
        // hardware events take precedence over software clears
        if (plug_stb[i])                        p_q <= 1'b1;
        else if (unplug_done[i] || do_eject[i]) p_q <= 1'b0;

        if (plug_stb[i] && plug_hot[i]) i_q <= 1'b1;
        else if (clr_ins[i])            i_q <= 1'b0;

        if (unplug_req[i])   r_q <= 1'b1;
        else if (clr_rmv[i]) r_q <= 1'b0;

        if (do_eject[i])     f_q <= 1'b0;
        else if (set_fwr[i]) f_q <= 1'b1;
      end
    end

    assign present[i]  = p_q;
    assign ins_pend[i] = i_q;
    assign rmv_pend[i] = r_q;
    assign fwr_pend[i] = f_q;
  end

endmodule

// File: rtl/cpuhp_next_pending.sv
module cpuhp_next_pending #(
  parameter int NSLOT = 4,
  parameter int IDX_W = 2
)(
  input  logic [NSLOT-1:0] pending,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] hit_idx
);

  // Rotating search; iterating from the far end lets the nearest hit win.
  always_comb begin
    found   = 1'b0;
    hit_idx = start;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      int cand;
      cand = int'(start) + k;
      if (cand >= NSLOT) cand = cand - NSLOT;
      if (pending[cand]) begin
        found   = 1'b1;
        hit_idx = IDX_W'(cand);
      end
    end
  end

endmodule

// File: rtl/cpuhp_regwin.sv
module cpuhp_regwin
  import cpuhp_pkg::*;
#(
  parameter int          NSLOT     = 4,
  parameter logic [63:0] ID_BASE   = 64'h0000_00A0_0000_0010,
  parameter logic [63:0] ID_STRIDE = 64'h0000_0001_0000_0101
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NSLOT-1:0] plug_stb,
  input  logic [NSLOT-1:0] plug_hot,
  input  logic [NSLOT-1:0] unplug_req,
  input  logic [NSLOT-1:0] unplug_done,
  output logic             evt_irq,
  output logic [NSLOT-1:0] eject_req,
  output logic             ost_stb,
  output logic [31:0]      ost_slot,
  output logic [31:0]      ost_event,
  output logic [31:0]      ost_status
);

  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [31:0]      sel_q;
  logic [7:0]       cmd_q;
  logic [31:0]      ost_ev_q [NSLOT];
  logic [31:0]      ost_st_q [NSLOT];

  logic             sel_valid;
  logic [IDX_W-1:0] sel_idx;
  logic [NSLOT-1:0] sel_hot;
  logic [1:0]       word;
  logic             wr_sel, wr_any, wr_flags, wr_cmd, wr_data;
  logic [7:0]       fbyte, cmd_new;
  logic             act_clr_ins, act_clr_rmv, act_eject, act_fwr, removable;
  logic             cmd_ok, scan_go;
  logic [NSLOT-1:0] present_vec, ins_vec, rmv_vec, fwr_vec;
  logic             nx_found;
  logic [IDX_W-1:0] nx_idx;
  logic [63:0]      cur_id;

  assign sel_valid = (sel_q < 32'(NSLOT));
  assign sel_idx   = sel_q[IDX_W-1:0];
  assign sel_hot   = sel_valid ? (NSLOT'(1) << sel_idx) : '0;
  assign word      = bus_addr[3:2];

  // write decode: only offset 0 is accepted with an invalid selector
  assign wr_sel   = bus_en && bus_we && (word == 2'd0);
  assign wr_any   = bus_en && bus_we && sel_valid;
  assign wr_flags = wr_any && (word == 2'd1) && bus_be[0];
  assign wr_cmd   = wr_any && (word == 2'd1) && bus_be[1];
  assign wr_data  = wr_any && (word == 2'd2);

  assign fbyte   = bus_wdata[7:0];
  assign cmd_new = bus_wdata[15:8];

  // priority decode of the flags byte
  assign act_clr_ins = wr_flags && fbyte[1];
  assign act_clr_rmv = wr_flags && !fbyte[1] && fbyte[2];
  assign act_eject   = wr_flags && !fbyte[1] && !fbyte[2] && fbyte[3];
  assign act_fwr     = wr_flags && !fbyte[1] && !fbyte[2] && !fbyte[3] && fbyte[4];
  assign removable   = sel_valid && present_vec[sel_idx] && (sel_idx != '0);

  assign eject_req = sel_hot & {NSLOT{act_eject && removable}};

  assign cmd_ok  = wr_cmd && (cmd_new < CMD_LIMIT);
  assign scan_go = cmd_ok && (cmd_new == CMD_SCAN);

  cpuhp_slot_bank #(.NSLOT(NSLOT)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .plug_stb    (plug_stb),
    .plug_hot    (plug_hot),
    .unplug_req  (unplug_req),
    .unplug_done (unplug_done),
    .clr_ins     (sel_hot & {NSLOT{act_clr_ins}}),
    .clr_rmv     (sel_hot & {NSLOT{act_clr_rmv}}),
    .do_eject    (eject_req),
    .set_fwr     (sel_hot & {NSLOT{act_fwr && removable}}),
    .present     (present_vec),
    .ins_pend    (ins_vec),
    .rmv_pend    (rmv_vec),
    .fwr_pend    (fwr_vec)
  );

  cpuhp_next_pending #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_next (
    .pending (ins_vec | rmv_vec | fwr_vec),
    .start   (sel_idx),
    .found   (nx_found),
    .hit_idx (nx_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cmd_q <= CMD_SCAN;
    end else begin
      if (wr_sel)                   sel_q <= merge_lanes(sel_q, bus_wdata, bus_be);
      else if (scan_go && nx_found) sel_q <= 32'(nx_idx);
      if (cmd_ok)                   cmd_q <= cmd_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        ost_ev_q[i] <= '0;
        ost_st_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (wr_data && sel_hot[i] && cmd_q == CMD_OST_EV) ost_ev_q[i] <= bus_wdata;
        if (wr_data && sel_hot[i] && cmd_q == CMD_OST_ST) ost_st_q[i] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ost_stb    <= 1'b0;
      ost_slot   <= '0;
      ost_event  <= '0;
      ost_status <= '0;
      evt_irq    <= 1'b0;
    end else begin
      ost_stb <= wr_data && (cmd_q == CMD_OST_ST);
      if (wr_data && cmd_q == CMD_OST_ST) begin
        ost_slot   <= sel_q;
        ost_event  <= ost_ev_q[sel_idx];
        ost_status <= bus_wdata;
      end
      evt_irq <= (|(plug_stb & plug_hot)) || (|unplug_req);
    end
  end

  assign cur_id = slot_id(ID_BASE, ID_STRIDE, int'(sel_idx));

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we && sel_valid) begin
      unique case (word)
        2'd0: bus_rdata = (cmd_q == CMD_ID) ? cur_id[63:32] : 32'd0;
        2'd1: bus_rdata = {24'd0, pack_flags(present_vec[sel_idx], ins_vec[sel_idx],
                                             rmv_vec[sel_idx], fwr_vec[sel_idx])};
        2'd2: begin
          if (cmd_q == CMD_ID)        bus_rdata = cur_id[31:0];
          else if (cmd_q == CMD_SCAN) bus_rdata = sel_q;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cpuhp_regwin_chk.sv
module cpuhp_regwin_chk #(
  parameter int NSLOT = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             sel_valid,
  input logic [7:0]       cmd_q,
  input logic [NSLOT-1:0] plug_stb,
  input logic [NSLOT-1:0] plug_hot,
  input logic [NSLOT-1:0] unplug_req,
  input logic             evt_irq,
  input logic [NSLOT-1:0] eject_req,
  input logic [NSLOT-1:0] present_vec,
  input logic             ost_stb
);

  a_r2_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !sel_valid) |-> (bus_rdata == 32'd0));

  a_r5_boot_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    eject_req[0] == 1'b0);

  a_r5_eject_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eject_req));

  a_r5_eject_clears_present: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eject_req) && !(|plug_stb)) |=> ((present_vec & $past(eject_req)) == '0));

  a_r6_bad_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[3:2] == 2'd1 && bus_be[1] && bus_wdata[15:8] >= 8'd4)
      |=> $stable(cmd_q));

  a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ost_stb) |-> $past(bus_en && bus_we && bus_addr[3:2] == 2'd2 &&
                             cmd_q == 8'd2 && sel_valid));

  a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(plug_stb & plug_hot)) || (|unplug_req)) |=> evt_irq);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(plug_stb & plug_hot)) || (|unplug_req)) |=> !evt_irq);

endmodule

bind cpuhp_regwin cpuhp_regwin_chk #(.NSLOT(NSLOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_be      (bus_be),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .sel_valid   (sel_valid),
  .cmd_q       (cmd_q),
  .plug_stb    (plug_stb),
  .plug_hot    (plug_hot),
  .unplug_req  (unplug_req),
  .evt_irq     (evt_irq),
  .eject_req   (eject_req),
  .present_vec (present_vec),
  .ost_stb     (ost_stb)
);

// File: tb/tb_cpuhp_regwin.sv
module tb_cpuhp_regwin;

  localparam int          NS     = 4;
  localparam logic [63:0] BASE   = 64'h0000_00A0_0000_0010;
  localparam logic [63:0] STRIDE = 64'h0000_0001_0000_0101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]    bus_addr = '0, bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] plug_stb = '0, plug_hot = '0, unplug_req = '0, unplug_done = '0;
  logic          evt_irq;
  logic [NS-1:0] eject_req;
  logic          ost_stb;
  logic [31:0]   ost_slot, ost_event, ost_status;

  int n_chk = 0, n_bad = 0;
  logic [NS-1:0] ej_seen;
  logic [31:0]   rv;
  bit            done = 0;

  always #10 clk = ~clk;

  cpuhp_regwin #(.NSLOT(NS), .ID_BASE(BASE), .ID_STRIDE(STRIDE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .plug_stb(plug_stb), .plug_hot(plug_hot),
    .unplug_req(unplug_req), .unplug_done(unplug_done), .evt_irq(evt_irq),
    .eject_req(eject_req), .ost_stb(ost_stb), .ost_slot(ost_slot),
    .ost_event(ost_event), .ost_status(ost_status));

  function automatic logic [31:0] id_half(input int s, input bit hi);
    logic [63:0] v;
    v = BASE;
    for (int k = 0; k < s; k++) v = v + STRIDE;
    return hi ? v[63:32] : v[31:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    #1 ej_seen = eject_req;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic pulse(input int kind, input logic [NS-1:0] m, input logic [NS-1:0] hot);
    case (kind)
      0: begin plug_stb = m; plug_hot = hot; end
      1: unplug_req = m;
      default: unplug_done = m;
    endcase
    @(negedge clk);
    plug_stb = '0; plug_hot = '0; unplug_req = '0; unplug_done = '0;
  endtask

  task automatic sel(input int s);
    wr(4'h0, 4'hF, 32'(s));
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(4'h4, 4'b0010, {16'd0, c, 8'd0});
  endtask

  task automatic flags(input logic [7:0] f);
    wr(4'h4, 4'b0001, {24'd0, f});
  endtask

  task automatic t_reset;
    rd(4'h4, rv); chk("R1", "flags after reset", rv, 0);
    rd(4'h8, rv); chk("R1", "data after reset", rv, 0);
    chk("R1", "irq after reset", 32'(evt_irq), 0);
    chk("R1", "ost_stb after reset", 32'(ost_stb), 0);
  endtask

  task automatic t_plug;
    pulse(0, 4'b0011, 4'b0000);
    chk("R9", "boot plug no irq", 32'(evt_irq), 0);
    pulse(0, 4'b0100, 4'b0100);
    chk("R9", "hot plug irq", 32'(evt_irq), 1);
    @(negedge clk);
    chk("R9", "irq one cycle", 32'(evt_irq), 0);
    pulse(0, 4'b1000, 4'b1000);
    pulse(2, 4'b1000, 4'b0000);
    sel(3); rd(4'h4, rv); chk("R9", "unplug_done clears present", rv, 32'h02);
    sel(2); rd(4'h4, rv); chk("R3", "hot slot flags", rv, 32'h03);
    sel(1); rd(4'h4, rv); chk("R3", "boot slot flags", rv, 32'h01);
  endtask

  task automatic t_scan;
    sel(0); cmd(8'd0);
    rd(4'h8, rv); chk("R10", "scan to slot 2", rv, 2);
    rd(4'h0, rv); chk("R7", "cmd0 high port zero", rv, 0);
    flags(8'h02); rd(4'h4, rv); chk("R4", "insert cleared", rv, 32'h01);
    cmd(8'd0); rd(4'h8, rv); chk("R10", "scan to slot 3", rv, 3);
    flags(8'h02); rd(4'h4, rv); chk("R4", "slot3 cleared", rv, 0);
    sel(1); cmd(8'd0); rd(4'h8, rv); chk("R10", "nothing pending keeps selector", rv, 1);
    pulse(1, 4'b0010, 4'b0000);
    chk("R9", "unplug request irq", 32'(evt_irq), 1);
    sel(3); cmd(8'd0); rd(4'h8, rv); chk("R10", "scan wraps to slot 1", rv, 1);
    rd(4'h4, rv); chk("R3", "remove pending flags", rv, 32'h05);
  endtask

  task automatic t_prio;
    flags(8'h06); rd(4'h4, rv); chk("R4", "bit1 wins over bit2", rv, 32'h05);
    flags(8'h0C); chk("R4", "bit2 blocks eject", 32'(ej_seen), 0);
    rd(4'h4, rv); chk("R4", "remove cleared", rv, 32'h01);
    flags(8'h10); rd(4'h4, rv); chk("R4", "firmware-remove set", rv, 32'h11);
    flags(8'h08); chk("R5", "eject pulse slot1", 32'(ej_seen), 32'h2);
    rd(4'h4, rv); chk("R5", "eject clears present and fwr", rv, 0);
    sel(2); flags(8'h18); chk("R4", "bit3 wins over bit4", 32'(ej_seen), 32'h4);
    rd(4'h4, rv); chk("R4", "no fwr after eject", rv, 0);
  endtask

  task automatic t_protect;
    sel(0); flags(8'h08); chk("R5", "boot eject refused", 32'(ej_seen), 0);
    rd(4'h4, rv); chk("R5", "boot stays present", rv, 32'h01);
    flags(8'h10); rd(4'h4, rv); chk("R5", "boot fwr refused", rv, 32'h01);
    sel(3); flags(8'h10); rd(4'h4, rv); chk("R5", "absent fwr refused", rv, 0);
    flags(8'h08); chk("R5", "absent eject refused", 32'(ej_seen), 0);
  endtask

  task automatic t_cmd;
    sel(2); cmd(8'd3);
    rd(4'h8, rv); chk("R7", "id low", rv, id_half(2, 0));
    rd(4'h0, rv); chk("R7", "id high", rv, id_half(2, 1));
    cmd(8'd7); rd(4'h8, rv); chk("R6", "code 7 ignored", rv, id_half(2, 0));
    cmd(8'hFF); rd(4'h8, rv); chk("R6", "code 255 ignored", rv, id_half(2, 0));
  endtask

  task automatic t_range;
    sel(9);
    rd(4'h0, rv); chk("R2", "invalid read 0", rv, 0);
    rd(4'h4, rv); chk("R2", "invalid read 4", rv, 0);
    rd(4'h8, rv); chk("R2", "invalid read 8", rv, 0);
    cmd(8'd0);
    sel(2); rd(4'h8, rv); chk("R2", "command write dropped", rv, id_half(2, 0));
  endtask

  task automatic t_bytes;
    wr(4'h0, 4'hF, 32'hFFFF_FF00);
    rd(4'h8, rv); chk("R11", "full selector write", rv, 0);
    wr(4'h0, 4'b0001, 32'h0000_0001);
    rd(4'h8, rv); chk("R11", "lane0 only", rv, 0);
    wr(4'h0, 4'b1110, 32'h0000_0000);
    rd(4'h8, rv); chk("R11", "upper lanes give slot 1", rv, id_half(1, 0));
    pulse(0, 4'b0010, 4'b0000);
    wr(4'h4, 4'b0010, 32'h0000_0010);
    rd(4'h4, rv); chk("R11", "flags lane not enabled", rv, 32'h01);
    rd(4'h8, rv); chk("R11", "command lane applied", rv, 1);
    wr(4'h4, 4'b0011, 32'h0000_0310);
    rd(4'h4, rv); chk("R11", "both lanes flags", rv, 32'h11);
    rd(4'h8, rv); chk("R11", "both lanes command", rv, id_half(1, 0));
  endtask

  task automatic t_ost;
    cmd(8'd1); wr(4'h8, 4'hF, 32'hABCD_0001);
    chk("R8", "no strobe on event write", 32'(ost_stb), 0);
    cmd(8'd2); rd(4'h8, rv); chk("R7", "cmd2 data reads zero", rv, 0);
    wr(4'h8, 4'hF, 32'h0000_0083);
    chk("R8", "strobe", 32'(ost_stb), 1);
    chk("R8", "slot", ost_slot, 1);
    chk("R8", "event word", ost_event, 32'hABCD_0001);
    chk("R8", "status word", ost_status, 32'h0000_0083);
    @(negedge clk);
    chk("R8", "strobe one cycle", 32'(ost_stb), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_plug;
    t_scan;
    t_prio;
    t_protect;
    t_cmd;
    t_range;
    t_bytes;
    t_ost;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule